// File: doc/BRIEF.md
# Privileged Instruction Trap Checker

This block sits beside the instruction decoder of a hart and decides, for one instruction at a time, whether a wait-for-interrupt or an address-translation fence may proceed. Three fence flavours are judged: the supervisor translation fence, the hypervisor translation fence and the guest-physical translation fence. The inputs are the current privilege, whether the hart runs virtualized, whether the supervisor and hypervisor extensions exist, and four trap-control bits: `wait_trap` (timeout wait), `vm_trap` (trap translation management), `guest_wait_trap` and `guest_vm_trap`, the last two being the guest-level counterparts.

The verdict is combinational in the cycle `req_valid` is high and comes as a 2-bit code. A fence that may proceed produces a one-cycle `flush_pulse` in the following cycle. A wait instruction that does not trap produces a one-cycle `halt_pulse` in the following cycle. The translation cache and the wakeup logic live elsewhere.

Top module: `priv_trap_gate`

## Requirements
- R1: After reset `flush_pulse` and `halt_pulse` are 0, and `verdict` is 0 in every cycle where `req_valid` is 0. Verdict codes are 0 proceed, 1 illegal-instruction, 2 virtual-instruction, 3 halt. Privilege codes are 0 user, 1 supervisor, and any code with bit 1 set is machine. Kind codes are 0 wait, 1 supervisor fence, 2 hypervisor fence, 3 guest-physical fence.
- R2: A wait gives verdict 1 when `wait_trap` is 1 and the privilege is supervisor, or when `wait_trap` is 1, the privilege is user and `has_s` is 0.
- R3: A wait in user mode gives verdict 1 when `has_s` is 1 and `virt_on` is 0, regardless of `wait_trap`.
- R4: When R2 and R3 do not apply, a wait with `virt_on` 1 gives verdict 2 in user mode, or in supervisor mode with `guest_wait_trap` 1.
- R5: A wait that does not trap gives verdict 3, and `halt_pulse` is 1 for exactly the next cycle.
- R6: A supervisor fence gives verdict 1 in user mode, and in supervisor mode when `vm_trap` is 1.
- R7: Otherwise a supervisor fence gives verdict 2 when `has_h`, `virt_on` and `guest_vm_trap` are all 1, and verdict 0 in every remaining case.
- R8: A hypervisor fence gives verdict 2 in supervisor mode with `virt_on` 1, verdict 0 in machine mode or non-virtualized supervisor mode, and verdict 1 otherwise (user mode).
- R9: A guest-physical fence gives verdict 1 in non-virtualized supervisor mode with `vm_trap` 1; otherwise it follows R8.
- R10: Any request with verdict 0 makes `flush_pulse` 1 for exactly the next cycle; a request with a trap verdict raises neither pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Instruction presented this cycle |
| req_kind | input | 2 | Instruction kind code |
| cur_priv | input | 2 | Current privilege code |
| virt_on | input | 1 | Hart runs virtualized |
| has_s | input | 1 | Supervisor extension present |
| has_h | input | 1 | Hypervisor extension present |
| wait_trap | input | 1 | Trap waits below machine mode |
| vm_trap | input | 1 | Trap translation management in supervisor mode |
| guest_wait_trap | input | 1 | Trap waits in virtualized supervisor mode |
| guest_vm_trap | input | 1 | Trap translation management in virtualized supervisor mode |
| verdict | output | 2 | Decision code, combinational |
| flush_pulse | output | 1 | Registered flush request |
| halt_pulse | output | 1 | Registered halt request |

## Verification
A fence that proceeds followed in the very next cycle by a wait puts the registered flush pulse of the first request in the same cycle as the combinational halt verdict of the second. The bench issues these two requests back to back and expects `flush_pulse` 1 together with `verdict` 3 in the second cycle, then `halt_pulse` 1 with `flush_pulse` 0 in the third. The reverse order, a wait then a fence, is also issued so that a halt pulse overlaps a proceed verdict.

// File: rtl/priv_trap_gate.sv
module priv_trap_gate (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [1:0] req_kind,
  input  logic [1:0] cur_priv,
  input  logic       virt_on,
  input  logic       has_s,
  input  logic       has_h,
  input  logic       wait_trap,
  input  logic       vm_trap,
  input  logic       guest_wait_trap,
  input  logic       guest_vm_trap,
  output logic [1:0] verdict,
  output logic       flush_pulse,
  output logic       halt_pulse
);
  localparam logic [1:0] V_GO   = 2'd0;
  localparam logic [1:0] V_ILL  = 2'd1;
  localparam logic [1:0] V_VIRT = 2'd2;
  localparam logic [1:0] V_HALT = 2'd3;

  localparam logic [1:0] K_WAIT  = 2'd0;
  localparam logic [1:0] K_SFNC  = 2'd1;
  localparam logic [1:0] K_HFNC  = 2'd2;

  logic in_u, in_s, in_m;
  assign in_m = cur_priv[1];
  assign in_s = (cur_priv == 2'd1);
  assign in_u = (cur_priv == 2'd0);

  logic wait_ill, wait_virt;
  assign wait_ill  = ((in_s || (!has_s && in_u)) && wait_trap) || (has_s && in_u && !virt_on);
  assign wait_virt = virt_on && (in_u || (in_s && guest_wait_trap));

  logic sf_ill, sf_virt;
  assign sf_ill  = in_u || (in_s && vm_trap);
  assign sf_virt = has_h && virt_on && guest_vm_trap;

  logic [1:0] hf_res;
  always_comb begin
    if (in_s && virt_on)                  hf_res = V_VIRT;
    else if (in_m || (in_s && !virt_on))  hf_res = V_GO;
    else                                  hf_res = V_ILL;
  end

  logic gf_ill;
  assign gf_ill = in_s && !virt_on && vm_trap;

  logic [1:0] decide;
  always_comb begin
    unique case (req_kind)
      K_WAIT:  decide = wait_ill ? V_ILL : (wait_virt ? V_VIRT : V_HALT);
      K_SFNC:  decide = sf_ill ? V_ILL : (sf_virt ? V_VIRT : V_GO);
      K_HFNC:  decide = hf_res;
      default: decide = gf_ill ? V_ILL : hf_res;
    endcase
  end

  assign verdict = req_valid ? decide : V_GO;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flush_pulse <= 1'b0;
      halt_pulse  <= 1'b0;
    end else begin
      flush_pulse <= req_valid && (decide == V_GO);
      halt_pulse  <= req_valid && (decide == V_HALT);
    end
  end
endmodule

// File: rtl/priv_trap_gate_chk.sv
module priv_trap_gate_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic [1:0] req_kind,
  input logic [1:0] cur_priv,
  input logic       virt_on,
  input logic [1:0] verdict,
  input logic       flush_pulse,
  input logic       halt_pulse
);
  // R10
  go_then_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && verdict == 2'd0) |=> flush_pulse);

  // R5
  halt_then_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && verdict == 2'd3) |=> halt_pulse);

  // R10
  flush_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_pulse |-> ($past(req_valid) && $past(verdict) == 2'd0));

  // R5
  pulses_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(flush_pulse && halt_pulse));

  // R1
  idle_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> verdict == 2'd0);

  // R4
  wait_never_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 2'd0) |-> verdict != 2'd0);

  // R8
  hfence_vs_virt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 2'd2 && cur_priv == 2'd1 && virt_on) |-> verdict == 2'd2);
endmodule

bind priv_trap_gate priv_trap_gate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
  .cur_priv(cur_priv), .virt_on(virt_on), .verdict(verdict),
  .flush_pulse(flush_pulse), .halt_pulse(halt_pulse)
);

// File: tb/test_priv_trap_gate.sv
`timescale 1ns/1ps
module test_priv_trap_gate;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_kind = 2'd0, cur_priv = 2'd0;
  logic virt_on = 0, has_s = 0, has_h = 0, wait_trap = 0, vm_trap = 0, guest_wait_trap = 0, guest_vm_trap = 0;
  logic [1:0] verdict;
  logic flush_pulse, halt_pulse;
  int checks = 0, errors = 0, cycles = 0;

  always #4 clk = ~clk;

  priv_trap_gate i_priv_trap_gate (.*);

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL R1 watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(string req, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic issue(string req, logic [1:0] k, logic [1:0] p, logic v, logic s, logic h,
                       logic tw, logic tvm, logic gtw, logic gtvm, logic [1:0] exp);
    @(negedge clk);
    req_valid = 1; req_kind = k; cur_priv = p; virt_on = v; has_s = s; has_h = h;
    wait_trap = tw; vm_trap = tvm; guest_wait_trap = gtw; guest_vm_trap = gtvm;
    #1 chk(req, verdict, exp);
    @(negedge clk);
    req_valid = 0;
    #1;
    chk({req, " flush R10"}, {1'b0, flush_pulse}, {1'b0, exp == 2'd0});
    chk({req, " halt R5"}, {1'b0, halt_pulse}, {1'b0, exp == 2'd3});
    chk({req, " idle R1"}, verdict, 2'd0);
    @(negedge clk);
    #1;
    chk({req, " pulses single R10"}, {flush_pulse, halt_pulse}, 2'b00);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 reset pulses", {flush_pulse, halt_pulse}, 2'b00);
    chk("R1 reset verdict", verdict, 2'd0);
  endtask

  task automatic t_wait;
    issue("R2 wait S tw", 0, 1, 0, 1, 1, 1, 0, 0, 0, 2'd1);
    issue("R2 wait U noS tw", 0, 0, 0, 0, 0, 1, 0, 0, 0, 2'd1);
    issue("R3 wait U S novirt", 0, 0, 0, 1, 1, 0, 0, 0, 0, 2'd1);
    issue("R4 wait U virt", 0, 0, 1, 1, 1, 0, 0, 0, 0, 2'd2);
    issue("R4 wait VS gtw", 0, 1, 1, 1, 1, 0, 0, 1, 0, 2'd2);
    issue("R2 wait VS tw beats gtw", 0, 1, 1, 1, 1, 1, 0, 1, 0, 2'd1);
    issue("R5 wait VS no gtw", 0, 1, 1, 1, 1, 0, 0, 0, 0, 2'd3);
    issue("R5 wait U noS notw", 0, 0, 0, 0, 0, 0, 0, 0, 0, 2'd3);
    issue("R5 wait M tw", 0, 3, 0, 1, 1, 1, 1, 1, 1, 2'd3);
  endtask

  task automatic t_sfence;
    issue("R6 sfence U", 1, 0, 0, 1, 1, 0, 0, 0, 0, 2'd1);
    issue("R6 sfence S tvm", 1, 1, 0, 1, 1, 0, 1, 0, 0, 2'd1);
    issue("R7 sfence VS gtvm", 1, 1, 1, 1, 1, 0, 0, 0, 1, 2'd2);
    issue("R7 sfence VS gtvm noH", 1, 1, 1, 1, 0, 0, 0, 0, 1, 2'd0);
    issue("R7 sfence S", 1, 1, 0, 1, 1, 0, 0, 0, 0, 2'd0);
    issue("R7 sfence M tvm", 1, 3, 0, 1, 1, 0, 1, 0, 0, 2'd0);
  endtask

  task automatic t_hfence;
    issue("R8 hfence VS", 2, 1, 1, 1, 1, 0, 0, 0, 0, 2'd2);
    issue("R8 hfence S", 2, 1, 0, 1, 1, 0, 1, 0, 0, 2'd0);
    issue("R8 hfence M", 2, 3, 0, 1, 1, 0, 0, 0, 0, 2'd0);
    issue("R8 hfence U", 2, 0, 0, 1, 1, 0, 0, 0, 0, 2'd1);
    issue("R8 hfence VU", 2, 0, 1, 1, 1, 0, 0, 0, 0, 2'd1);
  endtask

  task automatic t_gfence;
    issue("R9 gfence S tvm", 3, 1, 0, 1, 1, 0, 1, 0, 0, 2'd1);
    issue("R9 gfence VS tvm", 3, 1, 1, 1, 1, 0, 1, 0, 0, 2'd2);
    issue("R9 gfence S", 3, 1, 0, 1, 1, 0, 0, 0, 0, 2'd0);
    issue("R9 gfence M tvm", 3, 3, 0, 1, 1, 0, 1, 0, 0, 2'd0);
    issue("R9 gfence U", 3, 0, 0, 1, 1, 0, 0, 0, 0, 2'd1);
  endtask

  task automatic t_overlap;
    @(negedge clk);
    req_valid = 1; req_kind = 1; cur_priv = 3; virt_on = 0; has_s = 1; has_h = 1;
    wait_trap = 0; vm_trap = 0; guest_wait_trap = 0; guest_vm_trap = 0;
    #1 chk("R7 overlap fence", verdict, 2'd0);
    @(negedge clk);
    req_kind = 0;
    #1;
    chk("R5 overlap wait verdict", verdict, 2'd3);
    chk("R10 overlap flush", {1'b0, flush_pulse}, 2'd1);
    chk("R5 overlap no halt yet", {1'b0, halt_pulse}, 2'd0);
    @(negedge clk);
    req_kind = 2;
    #1;
    chk("R8 overlap hfence verdict", verdict, 2'd0);
    chk("R5 overlap halt", {flush_pulse, halt_pulse}, 2'b01);
    @(negedge clk);
    req_valid = 0;
    #1;
    chk("R10 overlap flush again", {flush_pulse, halt_pulse}, 2'b10);
    @(negedge clk);
    #1 chk("R10 overlap quiet", {flush_pulse, halt_pulse}, 2'b00);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk);
    rst_n = 1;
    t_wait();
    t_sfence();
    t_hfence();
    t_gfence();
    t_overlap();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule